// File: doc/BRIEF.md
# Sparse Pixel Array Readout Scanner

This block sequences the readout of a two-dimensional array of time-stamping pixels in the quiet interval between bunch trains. Once a start command arrives, it selects one row of the array at a time. The array returns that row's vector of per-pixel empty flags. A priority search over the vector jumps straight to the next pixel that holds data, so pixels with nothing stored never take up an output slot. An entirely empty row costs one clock.

For each occupied pixel the scanner walks the stored hit slots in order. It presents the addressed timestamp on a valid/ready stream, together with the pixel's row and column and a marker on the pixel's final hit. The first row is programmable. A value past the end of the array, such as 123, falls back to row 0. This lets a test confirm that row 0 works correctly for reasons other than being read first. Each real row is visited exactly once per scan, and a single-cycle done pulse closes the scan.

Top module: `sparse_readout_scanner`

## Requirements
- R1: After reset, out_valid_o and done_o are low, and the scanner waits for start_i.
- R2: start_i accepted while idle begins at row start_row_i when that value is below N_ROWS. Words leave in ascending column order within a row. Rows advance by one, and row N_ROWS-1 is followed by row 0.
- R3: A start_row_i at or above N_ROWS (for example 123) begins the scan at row 0.
- R4: Pixels whose empty flag is 1 produce no output word, and a row with no occupied pixel costs exactly one clock. For an all-empty array, done_o is high in the clock period that follows the N_ROWS-th rising edge after the edge that accepts start_i. A single hit not in the last column adds exactly one period to this.
- R5: Every stored hit of an occupied pixel is sent once, in slot order 0, 1, and so on. Each word carries the row, the column, the timestamp from pix_ts_i, and out_last_o = 1 only on the pixel's final hit. The final hit is the one where pix_last_i is 1 or where the slot index equals HIT_DEPTH-1.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o, the row, the column and the timestamp stay unchanged, and no word is lost.
- R7: After the last of the N_ROWS rows has been left, done_o is high for exactly one clock, and the scanner returns to idle with every word delivered.
- R8: start_i asserted during a scan has no effect: the word sequence is unchanged and only one done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Scan start request, taken only when idle |
| start_row_i | input | ROW_W | First row to scan; values at or above N_ROWS mean row 0 |
| sel_row_o | output | ROW_W | Row currently addressed in the array |
| sel_col_o | output | COL_W | Column currently addressed |
| sel_hit_o | output | HIT_W | Hit slot currently addressed within the pixel |
| row_empty_i | input | N_COLS | Empty flag per column of the addressed row, 1 = nothing stored |
| pix_ts_i | input | TS_W | Timestamp held in the addressed slot |
| pix_last_i | input | 1 | Addressed slot is the pixel's last stored hit |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_row_o | output | ROW_W | Row of the word |
| out_col_o | output | COL_W | Column of the word |
| out_ts_o | output | TS_W | Timestamp of the word |
| out_last_o | output | 1 | Final hit of this pixel |
| done_o | output | 1 | One-cycle pulse at scan end |

## Verification
A pixel's final handshake can coincide with leaving its row when the pixel sits in the last column. The scanner must then step the row and clear the column pointer in the same cycle, with no extra search cycle. If that row is also the final one, the done pulse must fire on that same edge. Scenarios place hits in column N_COLS-1 of the last-visited row and in a fully occupied row under random backpressure. The scoreboard then judges the exact word order, and the bench judges the clock count from start to done. A start request inside a running scan overlaps with row stepping. The bench checks that it neither reloads the row nor produces a second done.

// File: rtl/spr_pkg.sv
package spr_pkg;
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   function automatic int width_of(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/spr_col_find.sv
module spr_col_find #(
   parameter int N_COLS = 80,
   parameter int COL_W  = 7
) (
   input  logic [N_COLS-1:0] empty_i,
   input  logic [COL_W-1:0]  from_i,
   output logic              found_o,
   output logic [COL_W-1:0]  col_o
);
   logic [N_COLS-1:0] cand;

   for (genvar i = 0; i < N_COLS; i++) begin : g_cand
      assign cand[i] = !empty_i[i] && (i >= int'(from_i));
   end

   always_comb begin
      found_o = 1'b0;
      col_o   = '0;
      for (int i = N_COLS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found_o = 1'b1;
            col_o   = COL_W'(i);
         end
      end
   end

   // R4: a reported column is occupied and never behind the search pointer
   always_comb begin
      if (found_o) begin
         p_skip_r4: assert (!empty_i[col_o] && col_o >= from_i);
      end
   end
endmodule

// File: rtl/spr_row_seq.sv
module spr_row_seq #(
   parameter int N_ROWS = 80,
   parameter int ROW_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [ROW_W-1:0] start_row_i,
   input  logic             step_i,
   output logic [ROW_W-1:0] row_o,
   output logic             last_row_o
);
   localparam int LEFT_W = $clog2(N_ROWS + 1);

   logic [LEFT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_o  <= '0;
         left_q <= '0;
      end else if (load_i) begin
         row_o  <= (int'(start_row_i) >= N_ROWS) ? '0 : start_row_i;
         left_q <= LEFT_W'(N_ROWS);
      end else if (step_i) begin
         row_o  <= (int'(row_o) == N_ROWS - 1) ? '0 : row_o + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   assign last_row_o = (left_q == LEFT_W'(1));

   // R3: the addressed row always exists
   p_row_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(row_o) < N_ROWS);

   // R2: stepping off the top row wraps to row 0
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && int'(row_o) == N_ROWS - 1) |=> (row_o == '0));
endmodule

// File: rtl/sparse_readout_scanner.sv
module sparse_readout_scanner
   import spr_pkg::*;
#(
   parameter int N_ROWS    = 80,
   parameter int N_COLS    = 80,
   parameter int TS_W      = 14,
   parameter int HIT_DEPTH = 2,
   parameter int ROW_W     = 7,
   parameter int COL_W     = 7,
   parameter int HIT_W     = width_of(HIT_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ROW_W-1:0]  start_row_i,
   output logic [ROW_W-1:0]  sel_row_o,
   output logic [COL_W-1:0]  sel_col_o,
   output logic [HIT_W-1:0]  sel_hit_o,
   input  logic [N_COLS-1:0] row_empty_i,
   input  logic [TS_W-1:0]   pix_ts_i,
   input  logic              pix_last_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [ROW_W-1:0]  out_row_o,
   output logic [COL_W-1:0]  out_col_o,
   output logic [TS_W-1:0]   out_ts_o,
   output logic              out_last_o,
   output logic              done_o
);
   if (N_ROWS < 2 || N_COLS < 2) begin : g_bad_dims
      $error("scanner needs at least two rows and two columns");
   end
   if ((1 << ROW_W) < N_ROWS || (1 << COL_W) < N_COLS) begin : g_bad_addr
      $error("address widths too narrow for array size");
   end
   if (HIT_DEPTH < 1 || (1 << HIT_W) < HIT_DEPTH) begin : g_bad_hits
      $error("hit slot parameters inconsistent");
   end

   scan_state_e       state_q;
   logic              busy;
   logic              load;
   logic [COL_W-1:0]  col_ptr_q;
   logic              found;
   logic [COL_W-1:0]  fcol;
   logic [ROW_W-1:0]  row;
   logic              last_row;
   logic [HIT_W-1:0]  hit;
   logic              hit_cap;
   logic              fire;
   logic              final_hit;
   logic              pix_done;
   logic              row_leave;
   logic              finish;

   assign busy = (state_q == SCAN_RUN);
   assign load = !busy && start_i;

   spr_col_find #(.N_COLS(N_COLS), .COL_W(COL_W)) i_col_find (
      .empty_i (row_empty_i),
      .from_i  (col_ptr_q),
      .found_o (found),
      .col_o   (fcol)
   );

   spr_row_seq #(.N_ROWS(N_ROWS), .ROW_W(ROW_W)) i_row_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .start_row_i (start_row_i),
      .step_i      (row_leave),
      .row_o       (row),
      .last_row_o  (last_row)
   );

   assign out_valid_o = busy && found;
   assign fire        = out_valid_o && out_ready_i;
   assign final_hit   = pix_last_i || hit_cap;
   assign pix_done    = fire && final_hit;
   assign row_leave   = busy && (!found || (pix_done && int'(fcol) == N_COLS - 1));
   assign finish      = row_leave && last_row;

   if (HIT_DEPTH == 1) begin : g_single_slot
      assign hit     = '0;
      assign hit_cap = 1'b1;
   end else begin : g_multi_slot
      logic [HIT_W-1:0] hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_q <= '0;
         end else if (load || pix_done || row_leave) begin
            hit_q <= '0;
         end else if (fire) begin
            hit_q <= hit_q + 1'b1;
         end
      end
      assign hit     = hit_q;
      assign hit_cap = (hit_q == HIT_W'(HIT_DEPTH - 1));

      // R5: slot index never passes the pixel depth
      p_hit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
         int'(hit_q) < HIT_DEPTH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SCAN_IDLE;
         col_ptr_q <= '0;
         done_o    <= 1'b0;
      end else begin
         done_o <= finish;
         if (load) begin
            state_q   <= SCAN_RUN;
            col_ptr_q <= '0;
         end else if (busy) begin
            if (row_leave) begin
               col_ptr_q <= '0;
               if (last_row) state_q <= SCAN_IDLE;
            end else if (pix_done) begin
               col_ptr_q <= fcol + 1'b1;
            end
         end
      end
   end

   assign sel_row_o  = row;
   assign sel_col_o  = fcol;
   assign sel_hit_o  = hit;
   assign out_row_o  = row;
   assign out_col_o  = fcol;
   assign out_ts_o   = pix_ts_i;
   assign out_last_o = final_hit;

   // R6: a stalled word keeps its address and slot until taken
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=>
         (out_valid_o && $stable(out_row_o) && $stable(out_col_o) && $stable(sel_hit_o)));

   // R7: done lasts a single clock
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: a start during a scan does not reload the row
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i && !row_leave) |=> $stable(sel_row_o));

   // R1: nothing is offered while idle after the done pulse
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !out_valid_o || start_i);
endmodule

// File: tb/test_sparse_readout_scanner.sv
module test_sparse_readout_scanner;
   localparam int N_ROWS = 80;
   localparam int N_COLS = 80;
   localparam int TS_W = 14;
   localparam int HIT_DEPTH = 2;
   localparam int ROW_W = 7;
   localparam int COL_W = 7;
   localparam int HIT_W = 1;
   localparam int WORD_W = ROW_W + COL_W + TS_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [ROW_W-1:0] start_row = '0;
   logic [ROW_W-1:0] sel_row;
   logic [COL_W-1:0] sel_col;
   logic [HIT_W-1:0] sel_hit;
   logic [N_COLS-1:0] row_empty;
   logic [TS_W-1:0] pix_ts;
   logic pix_last;
   logic out_valid;
   logic ready = 1'b1;
   logic [ROW_W-1:0] out_row;
   logic [COL_W-1:0] out_col;
   logic [TS_W-1:0] out_ts;
   logic out_last;
   logic done;

   int checks = 0;
   int failures = 0;
   bit stall = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic [1:0] cnt [N_ROWS][N_COLS];
   logic [WORD_W-1:0] expq [$];
   logic [WORD_W-1:0] held;
   bit have_hold = 1'b0;

   always #4 clk = ~clk;

   sparse_readout_scanner #(
      .N_ROWS(N_ROWS), .N_COLS(N_COLS), .TS_W(TS_W), .HIT_DEPTH(HIT_DEPTH),
      .ROW_W(ROW_W), .COL_W(COL_W), .HIT_W(HIT_W)
   ) i_sparse_readout_scanner (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_row_i(start_row),
      .sel_row_o(sel_row), .sel_col_o(sel_col), .sel_hit_o(sel_hit),
      .row_empty_i(row_empty), .pix_ts_i(pix_ts), .pix_last_i(pix_last),
      .out_valid_o(out_valid), .out_ready_i(ready),
      .out_row_o(out_row), .out_col_o(out_col), .out_ts_o(out_ts),
      .out_last_o(out_last), .done_o(done)
   );

   function automatic logic [TS_W-1:0] ts_of(input int r, input int c, input int h);
      return TS_W'((r * 37 + c * 11 + h * 1013) ^ 16'h02A5);
   endfunction

   // pixel array model
   always_comb begin
      for (int c = 0; c < N_COLS; c++) row_empty[c] = (cnt[sel_row][c] == 2'd0);
      pix_ts   = ts_of(int'(sel_row), int'(sel_col), int'(sel_hit));
      pix_last = (int'(sel_hit) + 1 >= int'(cnt[sel_row][sel_col]));
   end

   always @(posedge clk) begin
      lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ready <= stall ? lfsr[0] : 1'b1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (have_hold) begin
            check(out_valid && {out_row, out_col, out_ts, out_last} == held,
                  "R6 held word", int'({out_row, out_col, out_ts}), int'(held[WORD_W-1:1]));
            have_hold = 1'b0;
         end
         if (out_valid && !ready) begin
            held = {out_row, out_col, out_ts, out_last};
            have_hold = 1'b1;
         end
         if (out_valid && ready) begin
            if (expq.size() == 0) begin
               check(1'b0, "R4 unexpected word", int'({out_row, out_col}), -1);
            end else begin
               logic [WORD_W-1:0] e;
               e = expq.pop_front();
               check({out_row, out_col, out_ts, out_last} == e, "R5 word",
                     int'({out_row, out_col, out_ts, out_last}), int'(e));
            end
         end
      end
   end

   task automatic clear_array();
      for (int r = 0; r < N_ROWS; r++)
         for (int c = 0; c < N_COLS; c++) cnt[r][c] = 2'd0;
   endtask

   task automatic build_expected(input int srow);
      int s0;
      s0 = (srow >= N_ROWS) ? 0 : srow;
      expq.delete();
      for (int k = 0; k < N_ROWS; k++) begin
         int r;
         r = (s0 + k) % N_ROWS;
         for (int c = 0; c < N_COLS; c++)
            for (int h = 0; h < int'(cnt[r][c]); h++)
               expq.push_back({ROW_W'(r), COL_W'(c), ts_of(r, c, h),
                               (h == int'(cnt[r][c]) - 1)});
      end
   endtask

   task automatic run_scan(input int srow, input bit poke, output int cycles);
      int dones;
      build_expected(srow);
      @(negedge clk);
      start = 1'b1;
      start_row = ROW_W'(srow);
      @(negedge clk);
      start = 1'b0;
      cycles = 1;
      dones = 0;
      while (!done && cycles < 20000) begin
         @(negedge clk);
         cycles++;
         if (poke && cycles == 5) begin start = 1'b1; start_row = 7'd40; end
         if (poke && cycles == 6) start = 1'b0;
      end
      check(done == 1'b1, "R7 done seen", int'(done), 1);
      if (done) dones++;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (done) dones++;
      end
      check(dones == 1, "R7/R8 single done pulse", dones, 1);
      check(expq.size() == 0, "R7 all words delivered", expq.size(), 0);
      check(!out_valid, "R7 idle after scan", int'(out_valid), 0);
   endtask

   task automatic place_sparse();
      clear_array();
      cnt[0][0] = 2'd1;
      cnt[0][79] = 2'd2;
      cnt[5][10] = 2'd1;
      cnt[5][11] = 2'd2;
      cnt[42][79] = 2'd1;
      cnt[79][40] = 2'd1;
      cnt[79][79] = 2'd2;
   endtask

   initial begin
      #1600000;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int cyc;
      clear_array();
      repeat (3) @(negedge clk);
      check(!out_valid, "R1 no valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R1 no valid after reset", int'(out_valid), 0);
      check(!done, "R1 no done after reset", int'(done), 0);

      // R4: all-empty array, one clock per row
      run_scan(0, 1'b0, cyc);
      check(cyc == N_ROWS + 1, "R4 empty scan length", cyc, N_ROWS + 1);

      // R4: one hit adds exactly one clock
      clear_array();
      cnt[10][5] = 2'd1;
      run_scan(0, 1'b0, cyc);
      check(cyc == N_ROWS + 2, "R4 single hit scan length", cyc, N_ROWS + 2);

      // R2/R5: sparse pattern from row 0
      place_sparse();
      run_scan(0, 1'b0, cyc);

      // R3: nonexistent start row 123 begins at row 0
      run_scan(123, 1'b0, cyc);

      // R2: start near the top wraps around
      run_scan(77, 1'b0, cyc);

      // R2: start on the last row, with backpressure
      stall = 1'b1;
      run_scan(79, 1'b0, cyc);

      // R6: dense row under random backpressure
      clear_array();
      for (int c = 0; c < N_COLS; c++) cnt[3][c] = (c % 3 == 0) ? 2'd2 : 2'd1;
      cnt[79][79] = 2'd2;
      run_scan(3, 1'b0, cyc);
      stall = 1'b0;

      // R8: start request mid-scan is ignored
      place_sparse();
      run_scan(0, 1'b1, cyc);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule